// File: doc/BRIEF.md
# Rotating Register File Renamer

This block is a register file with two read ports and one write port. The logical register space is divided into a rotating window, which sits at the low specifiers, and a fixed region above it. A rotating specifier is turned into a physical register index by adding a base offset and wrapping the sum modulo the window size. A fixed specifier selects the physical register of the same number.

Software-pipelined loops use it as follows. A one-cycle `rotate` pulse comes from the loop-closing branch and lowers the base by one on each iteration. Because of this, one static instruction that names the same logical specifier lands on a new physical register every iteration. A value written as logical register r can be read back as logical register r+k once k rotations have passed, so a producer-to-consumer latency is written as a difference between specifiers.

A synchronous `base_clr` input returns the base to zero before a new loop starts. The current base is visible on `rot_base`.

Top module: `rot_regfile`

## Requirements
- R1: After reset, `rot_base` is 0 and every register reads 0 on both read ports.
- R2: A specifier s below NROT (8) maps to physical register (s + base) mod NROT. For example, with a base of 3, specifier 1 selects physical register 4, which is the register that specifier 4 selects when the base is 0.
- R3: A specifier s of NROT or more maps to physical register s whatever the base.
- R4: A `rotate` pulse without `base_clr` lowers the base by one at the next rising edge. A base of 0 wraps to NROT-1 (7).
- R5: `base_clr` sets the base to 0 at the next rising edge and wins over a `rotate` asserted in the same cycle.
- R6: A value written to rotating specifier r is read at specifier r+k after k rotations, provided r+k < NROT.
- R7: When a read and a write target the same physical register in the same cycle, the read returns the old value. The new value becomes visible after the rising edge.
- R8: The two read ports decode their specifiers independently and may read different or identical registers in the same cycle.
- R9: While `wr_en` is low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_clr | input | 1 | Synchronous base clear, takes priority over rotate |
| rotate | input | 1 | One-cycle loop-branch strobe that lowers the base |
| ra_spec | input | SW | Read port A logical specifier |
| ra_data | output | W | Read port A data |
| rb_spec | input | SW | Read port B logical specifier |
| rb_data | output | W | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_spec | input | SW | Write logical specifier |
| wr_data | input | W | Write data |
| rot_base | output | BW | Current rotating base |

## Verification
The assertions take for granted that the control inputs `rotate`, `base_clr` and `wr_en` are never unknown once reset has been released. They also assume specifiers never exceed NROT+NSTAT-1, which is always true at the default sizes because the specifier width covers the space exactly. The random stimulus draws every specifier from the full range. It sets `rotate` and `base_clr` from independent random bits, so clears that collide with rotations come up often, and it forces frequent address collisions between the write port and the read ports. Directed cases cover the base-3 mapping example, the wrap from 0, and the specifier-difference read-back.

// File: rtl/rot_regfile.sv
module rot_regfile #(
  parameter int NROT  = 8,
  parameter int NSTAT = 8,
  parameter int W     = 16,
  localparam int NPHYS = NROT + NSTAT,
  localparam int SW    = $clog2(NPHYS),
  localparam int BW    = (NROT > 1) ? $clog2(NROT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_clr,
  input  logic          rotate,
  input  logic [SW-1:0] ra_spec,
  output logic [W-1:0]  ra_data,
  input  logic [SW-1:0] rb_spec,
  output logic [W-1:0]  rb_data,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_spec,
  input  logic [W-1:0]  wr_data,
  output logic [BW-1:0] rot_base
);

  logic [W-1:0]  rf [NPHYS];
  logic [BW-1:0] base_q;
  logic [SW-1:0] ra_phys, rb_phys, wr_phys;

  function automatic logic [SW-1:0] to_phys(input logic [SW-1:0] s, input logic [BW-1:0] b);
    logic [SW:0] sum;
    if ({1'b0, s} < (SW+1)'(NROT)) begin
      sum = {1'b0, s} + (SW+1)'(b);
      if (sum >= (SW+1)'(NROT)) sum = sum - (SW+1)'(NROT);
      return sum[SW-1:0];
    end
    return s;
  endfunction

  assign ra_phys  = to_phys(ra_spec, base_q);
  assign rb_phys  = to_phys(rb_spec, base_q);
  assign wr_phys  = to_phys(wr_spec, base_q);
  assign ra_data  = rf[ra_phys];
  assign rb_data  = rf[rb_phys];
  assign rot_base = base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else if (base_clr) base_q <= '0;
    else if (rotate) base_q <= (base_q == '0) ? BW'(NROT - 1) : base_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) rf[i] <= '0;
    end else if (wr_en) begin
      rf[wr_phys] <= wr_data;
    end
  end

  p_base_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, rot_base} < (BW+1)'(NROT));

  p_base_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rotate && !base_clr) |=>
      rot_base == (($past(rot_base) == '0) ? BW'(NROT - 1) : $past(rot_base) - 1'b1));

  p_clr_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    base_clr |=> rot_base == '0);

  p_base_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rotate && !base_clr) |=> $stable(rot_base));

  p_static_map_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, ra_spec} >= (SW+1)'(NROT)) |-> ra_phys == ra_spec);

  p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rf[$past(wr_phys)] == $past(wr_data));

  p_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rf[0]) && $stable(rf[NPHYS-1]));

endmodule

// File: tb/rot_regfile_test.sv
module rot_regfile_test;
  localparam int NROT = 8, NSTAT = 8, W = 16;
  localparam int NPHYS = NROT + NSTAT;
  localparam int SW = $clog2(NPHYS);
  localparam int BW = $clog2(NROT);

  logic clk = 0, rst_n = 0, base_clr = 0, rotate = 0, wr_en = 0;
  logic [SW-1:0] ra_spec = '0, rb_spec = '0, wr_spec = '0;
  logic [W-1:0] wr_data = '0, ra_data, rb_data;
  logic [BW-1:0] rot_base;

  int checks = 0, errors = 0;
  logic [W-1:0] mdl [NPHYS];
  int mbase = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rot_regfile #(.NROT(NROT), .NSTAT(NSTAT), .W(W)) uut (
    .clk(clk), .rst_n(rst_n), .base_clr(base_clr), .rotate(rotate),
    .ra_spec(ra_spec), .ra_data(ra_data), .rb_spec(rb_spec), .rb_data(rb_data),
    .wr_en(wr_en), .wr_spec(wr_spec), .wr_data(wr_data), .rot_base(rot_base));

  function automatic int phys(input int s, input int b);
    if (s < NROT) return (s + b) % NROT;
    return s;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drives the inputs after a falling edge, checks the reads before the rising
  // edge, then advances the model over that edge.
  task automatic step(input bit clr, input bit rot, input bit we, input int ws,
                      input logic [W-1:0] wd, input int a, input int b, input string req);
    @(negedge clk);
    base_clr = clr; rotate = rot; wr_en = we;
    wr_spec = SW'(ws); wr_data = wd; ra_spec = SW'(a); rb_spec = SW'(b);
    #1;
    chk(req, ra_data, mdl[phys(a, mbase)]);
    chk(req, rb_data, mdl[phys(b, mbase)]);
    @(posedge clk);
    if (we) mdl[phys(ws, mbase)] = wd;
    if (clr) mbase = 0;
    else if (rot) mbase = (mbase + NROT - 1) % NROT;
    #1;
    chk(req, rot_base, mbase);
    base_clr = 0; rotate = 0; wr_en = 0;
  endtask

  task automatic idle(input int a, input int b, input string req);
    step(0, 0, 0, 0, '0, a, b, req);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    for (int i = 0; i < NPHYS; i++) mdl[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 base", rot_base, 0);
    for (int i = 0; i < NPHYS; i += 2) begin
      ra_spec = SW'(i); rb_spec = SW'(i + 1); #1;
      chk("R1 read A", ra_data, 0);
      chk("R1 read B", rb_data, 0);
    end
    rst_n = 1;

    // R4 wrap from 0 to NROT-1
    step(0, 1, 0, 0, '0, 0, 1, "R4 wrap");
    chk("R4 wrap value", rot_base, NROT - 1);
    // R4 move the base down to 3
    repeat (4) step(0, 1, 0, 0, '0, 0, 0, "R4 decrement");
    chk("R4 base 3", rot_base, 3);
    // R2 base 3: spec 1 selects physical 4
    step(0, 0, 1, 1, 16'hA5A5, 2, 3, "R2 write");
    step(1, 0, 0, 0, '0, 4, 1, "R2 clear");
    idle(4, 1, "R2 read via spec4");
    @(negedge clk); ra_spec = 4; #1;
    chk("R2 phys4", ra_data, 16'hA5A5);

    // R5 clear beats rotate
    step(0, 1, 0, 0, '0, 0, 0, "R5 prep");
    step(1, 1, 0, 0, '0, 0, 0, "R5 priority");
    chk("R5 base zero", rot_base, 0);

    // R6 write at spec 2, read at spec 5 after 3 rotates
    step(0, 0, 1, 2, 16'h1234, 0, 0, "R6 write");
    repeat (3) step(0, 1, 0, 0, '0, 5, 2, "R6 rotate");
    @(negedge clk); ra_spec = 5; #1;
    chk("R6 readback", ra_data, 16'h1234);

    // R3 static spec unaffected by base
    step(0, 0, 1, 12, 16'hBEEF, 12, 12, "R3 write");
    step(0, 1, 0, 0, '0, 12, 12, "R3 rotate");
    @(negedge clk); ra_spec = 12; #1;
    chk("R3 static", ra_data, 16'hBEEF);

    // R7 same-cycle read returns the old value, new after the edge
    step(0, 0, 1, 9, 16'h7777, 9, 9, "R7 same cycle");
    @(negedge clk); ra_spec = 9; #1;
    chk("R7 after edge", ra_data, 16'h7777);

    // R9 write disabled changes nothing
    step(0, 0, 0, 9, 16'h0F0F, 9, 12, "R9 wr_en low");
    @(negedge clk); ra_spec = 9; rb_spec = 12; #1;
    chk("R9 spec9", ra_data, 16'h7777);
    chk("R9 spec12", rb_data, 16'hBEEF);

    // R8 R6 R7 random mix
    for (int n = 0; n < 3000; n++) begin
      int ws, a, b;
      ws = int'($urandom_range(NPHYS - 1));
      a  = ($urandom_range(3) == 0) ? ws : int'($urandom_range(NPHYS - 1));
      b  = int'($urandom_range(NPHYS - 1));
      step($urandom_range(15) == 0, $urandom_range(1), $urandom_range(1), ws,
           W'($urandom), a, b, "R8 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule